// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the hardwired control unit for a multi-cycle 32-bit load/store processor. The datapath has separate instruction and data memories. It also has an instruction register, two operand registers, an ALU result register and a memory data register. The sequencer walks through a fixed sequence of states for each instruction. In each state it drives the control points that the datapath needs for that step. It reads only two things from the datapath: the 6-bit opcode field of the instruction register and the equality flag from the ALU compare.

Every instruction starts with a fetch state and an operand-read state. The sequencer then dispatches on the opcode to a short chain of states for that instruction class: register-register ALU, OR with a zero-extended immediate, load word, store word, or branch-if-equal. The program counter is updated only in the final state of each instruction, and control then returns to fetch. The controls are a pure function of the state. They are produced by a register that is loaded together with the state register, so they change cleanly on the clock edge where the state changes.

Top module: `mcc_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the state at 0000 and outputs the fetch controls on the next cycle.
- R2: In state 0000 only `imem_rd` and `ir_en` are high, and the next state is always 0001.
- R3: In state 0001 only `a_en` and `b_en` are high. The next state depends on the opcode: 000000 goes to 0100, 001101 goes to 0110, 100011 goes to 1000, and 101011 goes to 1011. Opcode 000100 goes to 0010 when `zero` is 1 and to 0011 when it is 0.
- R4: Register-register: state 0100 drives `alu_sel`=10 (function from the funct field) and `r_en`. State 0101 drives `rf_wr`, `dst_rd`=1, `mem_to_reg`=0, `pc_en` and `pc_src`=01.
- R5: OR-immediate: state 0110 drives `alu_sel`=01 (OR) and `r_en`. State 0111 drives `rf_wr`, `dst_rd`=0, `mem_to_reg`=0, `pc_en` and `pc_src`=01.
- R6: Load: state 1000 drives `alu_sel`=00 (add) and `r_en`. State 1001 drives only `dmem_rd`. State 1010 drives `rf_wr`, `dst_rd`=0, `mem_to_reg`=1, `pc_en` and `pc_src`=01.
- R7: Store: state 1011 drives `alu_sel`=00 and `r_en`. State 1100 drives `dmem_wr`, `pc_en` and `pc_src`=01.
- R8: Branch: state 0010 drives `pc_en` with `pc_src`=10 (branch target). State 0011 drives `pc_en` with `pc_src`=01 (next sequential). Each lasts one cycle.
- R9: Any other opcode seen in state 0001 returns the sequencer to 0000 without asserting any write, memory or PC control.
- R10: `pc_src` is 00 (hold) whenever `pc_en` is low. Every state that asserts `pc_en` is followed by state 0000.
- R11: `state_o` only ever holds one of the 13 defined encodings. The encodings 1101–1111 would drive all controls low and exit to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | Operands-equal flag from the datapath |
| imem_rd | output | 1 | Instruction memory read |
| ir_en | output | 1 | Instruction register load |
| a_en | output | 1 | First operand register load |
| b_en | output | 1 | Second operand register load |
| alu_sel | output | 2 | ALU function: 00 add, 01 OR, 10 from funct |
| r_en | output | 1 | ALU result register load |
| dmem_rd | output | 1 | Data memory read into memory data register |
| dmem_wr | output | 1 | Data memory write |
| rf_wr | output | 1 | Register file write |
| dst_rd | output | 1 | Destination select: 1 rd field, 0 rt field |
| mem_to_reg | output | 1 | Write data select: 1 memory data, 0 ALU result |
| pc_en | output | 1 | Program counter load |
| pc_src | output | 2 | PC source: 00 hold, 01 PC+4, 10 branch target |
| state_o | output | 4 | Current state encoding |

## Verification
The assertions check these rules on every cycle:
- fetch always leads to operand read;
- the branch and load transitions follow their chains;
- unknown opcodes return to fetch;
- at most one memory or register-file access is active at a time;
- `pc_src` holds whenever `pc_en` is low;
- a PC update is always followed by fetch;
- the state encoding stays legal.

Only the bench scenarios can show that each instruction class produces exactly the right control word in each of its states. They also show that the zero flag steers the branch only when it is sampled in the operand-read state, and that a reset in the middle of an instruction abandons it cleanly.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int ST_W = 4;

  localparam logic [ST_W-1:0] S_FETCH = 4'b0000;
  localparam logic [ST_W-1:0] S_DEC   = 4'b0001;
  localparam logic [ST_W-1:0] S_BTK   = 4'b0010;
  localparam logic [ST_W-1:0] S_BNT   = 4'b0011;
  localparam logic [ST_W-1:0] S_REXE  = 4'b0100;
  localparam logic [ST_W-1:0] S_RWB   = 4'b0101;
  localparam logic [ST_W-1:0] S_OEXE  = 4'b0110;
  localparam logic [ST_W-1:0] S_OWB   = 4'b0111;
  localparam logic [ST_W-1:0] S_LADR  = 4'b1000;
  localparam logic [ST_W-1:0] S_LMEM  = 4'b1001;
  localparam logic [ST_W-1:0] S_LWB   = 4'b1010;
  localparam logic [ST_W-1:0] S_SADR  = 4'b1011;
  localparam logic [ST_W-1:0] S_SMEM  = 4'b1100;
  localparam logic [ST_W-1:0] S_LAST  = S_SMEM;

  localparam logic [1:0] ALU_ADD = 2'b00;
  localparam logic [1:0] ALU_OR  = 2'b01;
  localparam logic [1:0] ALU_FN  = 2'b10;

  localparam logic [1:0] PC_HOLD = 2'b00;
  localparam logic [1:0] PC_INC  = 2'b01;
  localparam logic [1:0] PC_BR   = 2'b10;

  typedef struct packed {
    logic       imem_rd;
    logic       ir_en;
    logic       a_en;
    logic       b_en;
    logic [1:0] alu_sel;
    logic       r_en;
    logic       dmem_rd;
    logic       dmem_wr;
    logic       rf_wr;
    logic       dst_rd;
    logic       mem_to_reg;
    logic       pc_en;
    logic [1:0] pc_src;
  } ctl_t;
endpackage

// File: rtl/mcc_next.sv
module mcc_next #(
  parameter int              OP_W   = 6,
  parameter logic [OP_W-1:0] OP_RTY = 6'b000000,
  parameter logic [OP_W-1:0] OP_ORI = 6'b001101,
  parameter logic [OP_W-1:0] OP_LW  = 6'b100011,
  parameter logic [OP_W-1:0] OP_SW  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ = 6'b000100
) (
  input  logic [mcc_pkg::ST_W-1:0] state,
  input  logic [OP_W-1:0]          opcode,
  input  logic                     zero,
  output logic [mcc_pkg::ST_W-1:0] nxt
);
  import mcc_pkg::*;

  logic [ST_W-1:0] dispatch;

  always_comb begin
    if (opcode == OP_RTY)      dispatch = S_REXE;
    else if (opcode == OP_ORI) dispatch = S_OEXE;
    else if (opcode == OP_LW)  dispatch = S_LADR;
    else if (opcode == OP_SW)  dispatch = S_SADR;
    else if (opcode == OP_BEQ) dispatch = zero ? S_BTK : S_BNT;
    else                       dispatch = S_FETCH;
  end

  always_comb begin
    case (state)
      S_FETCH: nxt = S_DEC;
      S_DEC:   nxt = dispatch;
      S_REXE:  nxt = S_RWB;
      S_OEXE:  nxt = S_OWB;
      S_LADR:  nxt = S_LMEM;
      S_LMEM:  nxt = S_LWB;
      S_SADR:  nxt = S_SMEM;
      default: nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_decode.sv
module mcc_decode (
  input  logic [mcc_pkg::ST_W-1:0] state,
  output mcc_pkg::ctl_t            ctl
);
  import mcc_pkg::*;

  always_comb begin
    ctl = '0;
    case (state)
      S_FETCH: begin
        ctl.imem_rd = 1'b1;
        ctl.ir_en   = 1'b1;
      end
      S_DEC: begin
        ctl.a_en = 1'b1;
        ctl.b_en = 1'b1;
      end
      S_REXE: begin
        ctl.alu_sel = ALU_FN;
        ctl.r_en    = 1'b1;
      end
      S_OEXE: begin
        ctl.alu_sel = ALU_OR;
        ctl.r_en    = 1'b1;
      end
      S_LADR, S_SADR: begin
        ctl.alu_sel = ALU_ADD;
        ctl.r_en    = 1'b1;
      end
      S_LMEM: ctl.dmem_rd = 1'b1;
      S_RWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.dst_rd = 1'b1;
        ctl.pc_en  = 1'b1;
        ctl.pc_src = PC_INC;
      end
      S_OWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.pc_en  = 1'b1;
        ctl.pc_src = PC_INC;
      end
      S_LWB: begin
        ctl.rf_wr      = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.pc_en      = 1'b1;
        ctl.pc_src     = PC_INC;
      end
      S_SMEM: begin
        ctl.dmem_wr = 1'b1;
        ctl.pc_en   = 1'b1;
        ctl.pc_src  = PC_INC;
      end
      S_BTK: begin
        ctl.pc_en  = 1'b1;
        ctl.pc_src = PC_BR;
      end
      S_BNT: begin
        ctl.pc_en  = 1'b1;
        ctl.pc_src = PC_INC;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl #(
  parameter int              OP_W   = 6,
  parameter logic [OP_W-1:0] OP_RTY = 6'b000000,
  parameter logic [OP_W-1:0] OP_ORI = 6'b001101,
  parameter logic [OP_W-1:0] OP_LW  = 6'b100011,
  parameter logic [OP_W-1:0] OP_SW  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ = 6'b000100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            zero,
  output logic            imem_rd,
  output logic            ir_en,
  output logic            a_en,
  output logic            b_en,
  output logic [1:0]      alu_sel,
  output logic            r_en,
  output logic            dmem_rd,
  output logic            dmem_wr,
  output logic            rf_wr,
  output logic            dst_rd,
  output logic            mem_to_reg,
  output logic            pc_en,
  output logic [1:0]      pc_src,
  output logic [3:0]      state_o
);
  import mcc_pkg::*;

  logic [ST_W-1:0] state_q, nxt, state_d;
  ctl_t            ctl_d, ctl_q;

  mcc_next #(
    .OP_W(OP_W), .OP_RTY(OP_RTY), .OP_ORI(OP_ORI),
    .OP_LW(OP_LW), .OP_SW(OP_SW), .OP_BEQ(OP_BEQ)
  ) u_next (
    .state (state_q),
    .opcode(opcode),
    .zero  (zero),
    .nxt   (nxt)
  );

  assign state_d = rst ? S_FETCH : nxt;

  mcc_decode u_dec (
    .state(state_d),
    .ctl  (ctl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
    ctl_q   <= ctl_d;
  end

  assign imem_rd    = ctl_q.imem_rd;
  assign ir_en      = ctl_q.ir_en;
  assign a_en       = ctl_q.a_en;
  assign b_en       = ctl_q.b_en;
  assign alu_sel    = ctl_q.alu_sel;
  assign r_en       = ctl_q.r_en;
  assign dmem_rd    = ctl_q.dmem_rd;
  assign dmem_wr    = ctl_q.dmem_wr;
  assign rf_wr      = ctl_q.rf_wr;
  assign dst_rd     = ctl_q.dst_rd;
  assign mem_to_reg = ctl_q.mem_to_reg;
  assign pc_en      = ctl_q.pc_en;
  assign pc_src     = ctl_q.pc_src;
  assign state_o    = state_q;

  logic op_known;
  assign op_known = (opcode == OP_RTY) || (opcode == OP_ORI) || (opcode == OP_LW) ||
                    (opcode == OP_SW)  || (opcode == OP_BEQ);

  p_fetch_next_r2: assert property (@(posedge clk) disable iff (rst)
    state_q == S_FETCH |=> state_q == S_DEC);

  p_beq_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DEC && opcode == OP_BEQ && zero) |=> state_q == S_BTK);

  p_load_chain_r6: assert property (@(posedge clk) disable iff (rst)
    state_q == S_LADR |=> (state_q == S_LMEM && dmem_rd));

  p_bad_op_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DEC && !op_known) |=> (state_q == S_FETCH && !rf_wr && !dmem_wr));

  p_one_access_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({imem_rd, dmem_rd, dmem_wr, rf_wr}));

  p_src_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !pc_en |-> pc_src == PC_HOLD);

  p_pc_last_r10: assert property (@(posedge clk) disable iff (rst)
    pc_en |=> state_q == S_FETCH);

  p_legal_state_r11: assert property (@(posedge clk) disable iff (rst)
    state_q <= S_LAST);
endmodule

// File: tb/sim_mcc_ctrl.sv
`timescale 1ns/1ps
module sim_mcc_ctrl;
  localparam logic [5:0] O_R = 6'b000000, O_ORI = 6'b001101, O_LW = 6'b100011,
                         O_SW = 6'b101011, O_BEQ = 6'b000100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic zero = 1'b0;
  logic imem_rd, ir_en, a_en, b_en, r_en, dmem_rd, dmem_wr, rf_wr, dst_rd, mem_to_reg, pc_en;
  logic [1:0] alu_sel, pc_src;
  logic [3:0] state_o;

  int total = 0;
  int bad = 0;
  logic [3:0] mstate = 4'd0;
  logic after_rst = 1'b1;
  logic bad_prev = 1'b0;

  always #2.5 clk = ~clk;

  mcc_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
    .imem_rd(imem_rd), .ir_en(ir_en), .a_en(a_en), .b_en(b_en),
    .alu_sel(alu_sel), .r_en(r_en), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .rf_wr(rf_wr), .dst_rd(dst_rd), .mem_to_reg(mem_to_reg),
    .pc_en(pc_en), .pc_src(pc_src), .state_o(state_o)
  );

  function automatic logic known(input logic [5:0] o);
    return o == O_R || o == O_ORI || o == O_LW || o == O_SW || o == O_BEQ;
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] s, input logic [5:0] o, input logic z);
    case (s)
      4'b0000: return 4'b0001;
      4'b0001: begin
        if (o == O_R)   return 4'b0100;
        if (o == O_ORI) return 4'b0110;
        if (o == O_LW)  return 4'b1000;
        if (o == O_SW)  return 4'b1011;
        if (o == O_BEQ) return z ? 4'b0010 : 4'b0011;
        return 4'b0000;
      end
      4'b0100: return 4'b0101;
      4'b0110: return 4'b0111;
      4'b1000: return 4'b1001;
      4'b1001: return 4'b1010;
      4'b1011: return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  // bits: imem ir a b | alu(2) | r dmrd dmwr rf dst m2r pcen | src(2)
  function automatic logic [14:0] exp_ctl(input logic [3:0] s);
    case (s)
      4'b0000: return 15'b1100_00_0000000_00;
      4'b0001: return 15'b0011_00_0000000_00;
      4'b0100: return 15'b0000_10_1000000_00;
      4'b0101: return 15'b0000_00_0001101_01;
      4'b0110: return 15'b0000_01_1000000_00;
      4'b0111: return 15'b0000_00_0001001_01;
      4'b1000: return 15'b0000_00_1000000_00;
      4'b1001: return 15'b0000_00_0100000_00;
      4'b1010: return 15'b0000_00_0001011_01;
      4'b1011: return 15'b0000_00_1000000_00;
      4'b1100: return 15'b0000_00_0010001_01;
      4'b0010: return 15'b0000_00_0000001_10;
      4'b0011: return 15'b0000_00_0000001_01;
      default: return 15'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] s);
    case (s)
      4'b0000: return "R2";
      4'b0001: return "R3";
      4'b0100, 4'b0101: return "R4";
      4'b0110, 4'b0111: return "R5";
      4'b1000, 4'b1001, 4'b1010: return "R6";
      4'b1011, 4'b1100: return "R7";
      4'b0010, 4'b0011: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check_now();
    logic [14:0] act;
    string t;
    act = {imem_rd, ir_en, a_en, b_en, alu_sel, r_en, dmem_rd, dmem_wr,
           rf_wr, dst_rd, mem_to_reg, pc_en, pc_src};
    t = after_rst ? "R1" : (bad_prev ? "R9" : tag_of(mstate));
    total++;
    if (state_o !== mstate) begin
      bad++;
      $display("FAIL %s state act=%b exp=%b", t, state_o, mstate);
    end
    total++;
    if (act !== exp_ctl(mstate)) begin
      bad++;
      $display("FAIL %s ctl act=%b exp=%b (state %b)", t, act, exp_ctl(mstate), mstate);
    end
    total++;
    if (state_o > 4'b1100) begin // R11 legal encodings on every cycle
      bad++;
      $display("FAIL R11 state act=%b exp=<=1100", state_o);
    end
    total++;
    if (!pc_en && pc_src !== 2'b00) begin // R10 hold when not updating
      bad++;
      $display("FAIL R10 pc_src act=%b exp=00", pc_src);
    end
  endtask

  task automatic step(input logic [5:0] o, input logic z, input logic r);
    check_now();
    bad_prev  = (mstate == 4'b0001) && !known(o) && !r;
    after_rst = r;
    opcode = o;
    zero   = z;
    rst    = r;
    mstate = r ? 4'b0000 : exp_next(mstate, o, z);
    @(negedge clk);
  endtask

  task automatic run_instr(input logic [5:0] o, input logic z);
    for (int i = 0; i < 6; i++) begin
      step(o, z, 1'b0);
      if (mstate == 4'b0000) break;
    end
  endtask

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    mstate = 4'b0000;
    after_rst = 1'b1;
    // R1 reset state, then directed walk through each class
    step(O_R, 1'b0, 1'b1);
    run_instr(O_R, 1'b0);      // R4
    run_instr(O_ORI, 1'b1);    // R5
    run_instr(O_LW, 1'b0);     // R6
    run_instr(O_SW, 1'b1);     // R7
    run_instr(O_BEQ, 1'b1);    // R8 taken
    run_instr(O_BEQ, 1'b0);    // R8 not taken
    run_instr(6'h3F, 1'b1);    // R9 unknown opcode
    run_instr(6'h01, 1'b0);    // R9 another unknown opcode
    // R1 reset in the middle of a load
    step(O_LW, 1'b0, 1'b0);
    step(O_LW, 1'b0, 1'b0);
    step(O_LW, 1'b0, 1'b0);
    step(O_LW, 1'b0, 1'b1);
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] o;
      int sel;
      sel = $urandom % 8;
      case (sel)
        0: o = O_R;
        1: o = O_ORI;
        2: o = O_LW;
        3: o = O_SW;
        4, 5: o = O_BEQ;
        default: o = 6'($urandom);
      endcase
      step(o, 1'($urandom), (n % 997) == 996);
    end
    check_now();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule